// File: doc/BRIEF.md
# Four-Beat Burst Word Address Sequencer

This block produces the word address for a four-beat burst. A load cycle captures a full external address. The two least significant bits of that address become the first beat. Each later advance cycle moves the low two bits to the next beat. The `interleave` input picks the beat order: the start value plus the beat count gives linear order, and the start value XORed with the beat count gives interleaved order. The bits above the low two keep the value captured at the load for the whole burst, including after the burst wraps.

The controller that drives the block marks each enabled cycle in one of two ways: `adv` low loads an address, and `adv` high steps the burst. A load with `sel_ok` low is a deselect, and it ends the burst in progress. When `clk_en` is low, every register holds its value. Both outputs are registered, so they update one clock after the cycle that caused the change.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `word_addr` becomes 0 and `burst_act` becomes 0.
- R2: In an enabled cycle (`clk_en`=1) with `adv`=0 and `sel_ok`=1, the next cycle shows `word_addr` equal to `addr_in` and `burst_act`=1. The beat count restarts at 0.
- R3: With `interleave`=0, advance k (k = 1, 2, 3) of a burst sets the low two bits of `word_addr` to (start + k) mod 4. For example, start 2 gives 2,3,0,1.
- R4: With `interleave`=1, advance k of a burst sets the low two bits to start XOR k. For example, start 1 gives 1,0,3,2.
- R5: Advances past the fourth beat wrap to the start of the sequence, and the same group of four repeats. The bits of `word_addr` above bit 1 never change on an advance.
- R6: An enabled cycle with `adv`=0 and `sel_ok`=0 clears `burst_act` in the next cycle and leaves `word_addr` unchanged.
- R7: When `clk_en`=0, `word_addr` and `burst_act` hold their values whatever the other inputs do. The burst then continues from where it stopped.
- R8: An enabled advance while `burst_act`=0 leaves `word_addr` unchanged and keeps `burst_act` at 0.
- R9: A load during a burst discards the old sequence. Later advances follow the new start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Cycle enable; 0 freezes all state |
| adv | input | 1 | 1 = step the burst, 0 = load (or deselect) |
| sel_ok | input | 1 | Chip selection valid during a load cycle |
| interleave | input | 1 | Beat order: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External address captured on load |
| word_addr | output | ADDR_W | Current word address (registered) |
| burst_act | output | 1 | A burst is loaded and not ended |

## Verification
The bench loads every start value in both orders and steps five beats past each load. An adder that carried into bit 2, or a sequence that failed to wrap, would show up as a wrong upper address or a wrong fifth beat. An interleave path swapped with the linear one would agree only for start 0 and start 2, so the odd start values expose it. Freezes driven with conflicting inputs, a reload in the middle of a burst, and advances after a deselect or straight after reset catch a design that counts through a stall, keeps the stale start value, or lets an idle advance move the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Operation the sequencer performs in one clock
  typedef enum logic [1:0] {
    SEQ_HOLD = 2'd0,
    SEQ_LOAD = 2'd1,
    SEQ_STEP = 2'd2,
    SEQ_STOP = 2'd3
  } seq_op_e;

  function automatic seq_op_e seq_decode(input logic en, input logic adv,
                                         input logic sel, input logic act);
    seq_op_e op;
    if (!en)       op = SEQ_HOLD;
    else if (!adv) op = sel ? SEQ_LOAD : SEQ_STOP;
    else if (act)  op = SEQ_STEP;
    else           op = SEQ_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_op_e           op,
  input  logic [BEAT_W-1:0] start_in,
  output logic              active,
  output logic [BEAT_W-1:0] start_val,
  output logic [BEAT_W-1:0] beat_nxt
);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      start_val <= '0;
      beat_q    <= '0;
    end else begin
      case (op)
        SEQ_LOAD: begin
          active    <= 1'b1;
          start_val <= start_in;
          beat_q    <= '0;
        end
        SEQ_STEP: beat_q <= beat_nxt;
        SEQ_STOP: active <= 1'b0;
        default: ;
      endcase
    end
  end

  // The counter is BEAT_W bits wide, so it wraps within the group
  assign beat_nxt = beat_q + 1'b1;

endmodule

// File: rtl/burst_order.sv
module burst_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_val,
  input  logic [BEAT_W-1:0] beat,
  input  logic              interleave,
  output logic [BEAT_W-1:0] idx
);

  logic [BEAT_W-1:0] lin_idx;
  logic [BEAT_W-1:0] ilv_idx;

  always_comb begin
    lin_idx = start_val + beat;
    ilv_idx = start_val ^ beat;
    idx     = interleave ? ilv_idx : lin_idx;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_act
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  seq_op_e            op;
  logic [BEAT_W-1:0]  start_val;
  logic [BEAT_W-1:0]  beat_nxt;
  logic [BEAT_W-1:0]  next_idx;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  low_q;

  assign op = seq_decode(clk_en, adv, sel_ok, burst_act);

  burst_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .start_in  (addr_in[BEAT_W-1:0]),
    .active    (burst_act),
    .start_val (start_val),
    .beat_nxt  (beat_nxt)
  );

  burst_order #(.BEAT_W(BEAT_W)) u_order (
    .start_val  (start_val),
    .beat       (beat_nxt),
    .interleave (interleave),
    .idx        (next_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      low_q   <= '0;
    end else begin
      case (op)
        SEQ_LOAD: begin
          upper_q <= addr_in[ADDR_W-1:BEAT_W];
          low_q   <= addr_in[BEAT_W-1:0];
        end
        SEQ_STEP: low_q <= next_idx;
        default: ;
      endcase
    end
  end

  assign word_addr = {upper_q, low_q};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              adv,
  input logic              sel_ok,
  input logic              interleave,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] word_addr,
  input logic              burst_act
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && sel_ok) |=> (burst_act && word_addr == $past(addr_in)));

  // R6
  deselect_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv && !sel_ok) |=> (!burst_act && $stable(word_addr)));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(word_addr) && $stable(burst_act)));

  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

  // R8
  idle_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv && !burst_act) |=> ($stable(word_addr) && !burst_act));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv && burst_act && !interleave) |=>
      (word_addr[BEAT_W-1:0] == BEAT_W'($past(word_addr[BEAT_W-1:0]) + 1'b1)));

  // R4
  interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv && burst_act && interleave) |=>
      (word_addr[0] != $past(word_addr[0])));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_en     (clk_en),
  .adv        (adv),
  .sel_ok     (sel_ok),
  .interleave (interleave),
  .addr_in    (addr_in),
  .word_addr  (word_addr),
  .burst_act  (burst_act)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

  localparam int AW = 20;
  localparam real HALF = 10.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b0;
  logic          adv = 1'b0;
  logic          sel_ok = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] word_addr;
  logic          burst_act;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [AW-1:0] m_addr = '0;
  bit            m_act = 1'b0;
  int            m_start = 0;
  int            m_beat = 0;

  always #(HALF) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .adv(adv), .sel_ok(sel_ok),
    .interleave(interleave), .addr_in(addr_in),
    .word_addr(word_addr), .burst_act(burst_act)
  );

  task automatic compare(input string req);
    n_run++;
    if (word_addr !== m_addr || burst_act !== m_act) begin
      n_fail++;
      $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0b",
               req, word_addr, burst_act, m_addr, m_act);
    end
  endtask

  // called at a negedge: drive, clock, update model, compare at next negedge
  task automatic cyc(input bit en, input bit a, input bit s, input bit m,
                     input logic [AW-1:0] ad, input string req);
    int lo;
    clk_en = en; adv = a; sel_ok = s; interleave = m; addr_in = ad;
    @(posedge clk);
    if (en) begin
      if (!a) begin
        if (s) begin
          m_act = 1; m_start = int'(ad[1:0]); m_beat = 0; m_addr = ad;
        end else begin
          m_act = 0;
        end
      end else if (m_act) begin
        m_beat = (m_beat + 1) % 4;
        lo = m ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
        m_addr[1:0] = lo[1:0];
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    // R8: advances straight after reset
    cyc(1, 1, 1, 0, 20'hABCDE, "R8");
    cyc(1, 1, 0, 1, 20'h13579, "R8");
    // R2 R3 R4 R5: every start value in both orders, five advances each
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1, 0, 1, m[0], {18'h2D4C1 + 18'(s * 7), 2'(s)}, "R2");
        for (int k = 0; k < 5; k++)
          cyc(1, 1, 1, m[0], 20'hFFFFF, m ? (k < 3 ? "R4" : "R5") : (k < 3 ? "R3" : "R5"));
      end
    end
    // R7: freeze with conflicting inputs mid-burst, then resume
    cyc(1, 0, 1, 0, 20'h0F0F1, "R2");
    cyc(1, 1, 1, 0, 20'h0, "R3");
    cyc(0, 0, 1, 0, 20'h77772, "R7");
    cyc(0, 0, 0, 1, 20'h11113, "R7");
    cyc(0, 1, 1, 0, 20'h22220, "R7");
    cyc(1, 1, 1, 0, 20'h0, "R7");
    // R9: reload mid-burst
    cyc(1, 0, 1, 1, 20'h5A5A3, "R9");
    cyc(1, 1, 1, 1, 20'h0, "R9");
    cyc(1, 1, 1, 1, 20'h0, "R9");
    // R6: deselect, then R8 advances while idle
    cyc(1, 0, 0, 1, 20'h99990, "R6");
    cyc(1, 1, 1, 1, 20'h0, "R8");
    cyc(1, 1, 1, 0, 20'h0, "R8");
    cyc(0, 0, 1, 0, 20'h44441, "R7");
    // R1: reset during an active burst
    cyc(1, 0, 1, 0, 20'h33332, "R2");
    rst = 1'b1;
    @(posedge clk);
    m_addr = '0; m_act = 0; m_beat = 0; m_start = 0;
    @(negedge clk);
    compare("R1");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule